// File: doc/BRIEF.md
# Parallel flash command state machine

This block is the device-side command interpreter of a small byte-wide NOR-style flash array whose cells are ordinary on-chip registers. A host issues bus write cycles (address, data and a single-cycle write strobe). The block recognises multi-cycle unlock sequences that lead to a byte program, a whole-array erase or an erase of one or more sectors. It then runs the chosen operation on its own, timed by a cycle counter whose durations are parameters.

Reads are combinational. In read mode the addressed byte comes back. While an operation is running, every read returns a polling status word whose top bit tells the host whether the work is done. Programming can only clear bits. Only an erase brings bits back to 1. Sector erases collect during a short window that restarts on each added sector, and the erase begins when that window runs out.

Top module: `flash_cmd_top`

## Requirements
- R1: From read mode, a byte program needs four writes in this order: AAh at address 555h, then 55h at 2AAh, then A0h at 555h, then the target address with its data. A write that arrives outside this sequence (for example A0h at 555h with no unlock before it) leaves the array unchanged.
- R2: A program stores the old byte ANDed with the written data, so bits can only go from 1 to 0.
- R3: After the data write of a program, reads at any address return 80h if bit 7 of the written data is 0, or 00h if it is 1. This lasts for exactly PGM_CYCLES cycles. After that, reads return array contents.
- R4: The write sequence AAh@555h, 55h@2AAh, 80h@555h, AAh@555h, 55h@2AAh, 10h@555h starts a chip erase. Reads return 00h for PRE_CYCLES + ERASE_CYCLES cycles. After that, every byte reads FFh.
- R5: When the same five lead-in writes are followed by 30h at any address, the sector that address falls in is marked for erase. The sector is given by bits 5:4 of the address. Each further 30h write marks its own sector and restarts a window of WIN_CYCLES cycles. When the window has run out, an erase of ERASE_CYCLES cycles follows. During the window and the erase, reads return 00h. Afterwards, the marked sectors read FFh and all other sectors keep their data.
- R6: Writes of any kind made while a program or erase is running are ignored. They do not change the array, they do not change how long the operation takes, and they do not start a new command.
- R7: A command cycle with the wrong address or data returns the block to read mode, and the array is unchanged. A write of F0h counts as such a wrong cycle. The data cycle of a program is not a command cycle, so any value is accepted there.
- R8: After reset the block is in read mode and every byte reads FFh.
- R9: A write other than 30h during the sector window drops the pending sector erase. The block returns to read mode and the marked sectors keep their data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | ADDR_W | Bus address for reads and writes; the low log2(DEPTH) bits select the byte |
| busWrData | input | 8 | Write data |
| busWrEn | input | 1 | Write strobe, one cycle per bus write |
| busRdData | output | 8 | Array byte in read mode, polling status while busy |

## Verification
The assertions assume that each bus write is a single-cycle strobe sampled on a rising edge, with its address and data held steady through that edge. They also assume that nothing is written during reset. The stimulus sets address, data and strobe just after an edge and drops the strobe just after the next edge. Reads are sampled on the falling edge, so the combinational read path has settled. Busy-period durations are counted by reading once per cycle from the write edge onward, so every status cycle and the first cycle of array data are checked.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
  localparam int DATA_W = 8;

  localparam logic [DATA_W-1:0] CMD_KEY1   = 8'hAA;
  localparam logic [DATA_W-1:0] CMD_KEY2   = 8'h55;
  localparam logic [DATA_W-1:0] CMD_PROG   = 8'hA0;
  localparam logic [DATA_W-1:0] CMD_ESETUP = 8'h80;
  localparam logic [DATA_W-1:0] CMD_CHIP   = 8'h10;
  localparam logic [DATA_W-1:0] CMD_SECT   = 8'h30;

  typedef struct packed {
    logic latchPgm;
    logic doProgram;
    logic addSector;
    logic allSectors;
    logic zeroAll;
    logic eraseMasked;
    logic clearMask;
  } flStrobe_t;

  typedef enum logic [1:0] {
    RD_ARRAY,
    RD_PGM_STATUS,
    RD_ERASE_STATUS
  } rdMode_t;
endpackage

// File: rtl/flash_cmd_datapath.sv
module flash_cmd_datapath
  import flash_cmd_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int NSECT = 4
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  flStrobe_t                strb,
  input  rdMode_t                  rdMode,
  input  logic [$clog2(DEPTH)-1:0] busIdx,
  input  logic [DATA_W-1:0]        wrData,
  output logic [DATA_W-1:0]        rdData
);
  localparam int IDX_W  = $clog2(DEPTH);
  localparam int SECT_W = $clog2(NSECT);
  localparam int SPS    = DEPTH / NSECT;

  logic [DEPTH-1:0][DATA_W-1:0] mem;
  logic [NSECT-1:0]             sectMask;
  logic [IDX_W-1:0]             pgmIdx;
  logic [DATA_W-1:0]            pgmData;
  logic [DEPTH-1:0]             eraseHit;
  logic [SECT_W-1:0]            busSect;

  assign busSect = busIdx[IDX_W-1 -: SECT_W];

  for (genvar g = 0; g < DEPTH; g++) begin : g_hit
    localparam int SOWN = g / SPS;
    assign eraseHit[g] = strb.eraseMasked & sectMask[SOWN];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mem      <= '1;
      sectMask <= '0;
      pgmIdx   <= '0;
      pgmData  <= '0;
    end else begin
      if (strb.latchPgm) begin
        pgmIdx  <= busIdx;
        pgmData <= wrData;
      end
      for (int i = 0; i < DEPTH; i++) begin
        if (strb.zeroAll)
          mem[i] <= '0;
        else if (eraseHit[i])
          mem[i] <= '1;
        else if (strb.doProgram && pgmIdx == IDX_W'(i))
          mem[i] <= mem[i] & pgmData;
      end
      if (strb.eraseMasked || strb.clearMask)
        sectMask <= '0;
      else if (strb.allSectors)
        sectMask <= '1;
      else if (strb.addSector)
        sectMask[busSect] <= 1'b1;
    end
  end

  always_comb begin
    case (rdMode)
      RD_PGM_STATUS:   rdData = {~pgmData[DATA_W-1], {(DATA_W-1){1'b0}}};
      RD_ERASE_STATUS: rdData = '0;
      default:         rdData = mem[busIdx];
    endcase
  end

  // R2: a program can only clear bits of the latched location
  p_prog_and_r2: assert property (@(posedge clk) disable iff (!rstN)
    strb.doProgram |=> mem[$past(pgmIdx)] == ($past(mem[pgmIdx]) & $past(pgmData)));

  // R6: with no array-changing strobe the array holds
  p_idle_stable_r6: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.doProgram || strb.zeroAll || strb.eraseMasked) |=> $stable(mem));

  // R5: a marked sector reads erased after the erase strobe
  p_erase_ones_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strb.eraseMasked && sectMask[0]) |=> mem[0] == '1);
endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W      = 12,
  parameter int PGM_CYCLES  = 8,
  parameter int WIN_CYCLES  = 16,
  parameter int PRE_CYCLES  = 12,
  parameter int ERASE_CYCLES = 20
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWrData,
  input  logic              busWrEn,
  output flStrobe_t         strb,
  output rdMode_t           rdMode
);
  localparam int MAX_A = (PGM_CYCLES > WIN_CYCLES) ? PGM_CYCLES : WIN_CYCLES;
  localparam int MAX_B = (PRE_CYCLES > ERASE_CYCLES) ? PRE_CYCLES : ERASE_CYCLES;
  localparam int MAX_C = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W = $clog2(MAX_C + 1);
  localparam logic [ADDR_W-1:0] ADR_A = ADDR_W'(12'h555);
  localparam logic [ADDR_W-1:0] ADR_B = ADDR_W'(12'h2AA);
  localparam logic [CNT_W-1:0] LD_PGM = CNT_W'(PGM_CYCLES - 1);
  localparam logic [CNT_W-1:0] LD_WIN = CNT_W'(WIN_CYCLES - 1);
  localparam logic [CNT_W-1:0] LD_PRE = CNT_W'(PRE_CYCLES - 1);
  localparam logic [CNT_W-1:0] LD_ERS = CNT_W'(ERASE_CYCLES - 1);

  typedef enum logic [3:0] {
    S_READ, S_UNL1, S_UNL2, S_PSET, S_ESET, S_EUNL1, S_EUNL2,
    S_WIN, S_PGM, S_PRE, S_ERASE
  } ctlState_t;

  ctlState_t        state, nextState;
  logic [CNT_W-1:0] cnt, nextCnt;
  logic             isKey1, isKey2, isProg, isESet, isChip, isSect;

  assign isKey1 = busWrEn && busAddr == ADR_A && busWrData == CMD_KEY1;
  assign isKey2 = busWrEn && busAddr == ADR_B && busWrData == CMD_KEY2;
  assign isProg = busWrEn && busAddr == ADR_A && busWrData == CMD_PROG;
  assign isESet = busWrEn && busAddr == ADR_A && busWrData == CMD_ESETUP;
  assign isChip = busWrEn && busAddr == ADR_A && busWrData == CMD_CHIP;
  assign isSect = busWrEn && busWrData == CMD_SECT;

  always_comb begin
    nextState = state;
    nextCnt   = cnt;
    strb      = '0;
    case (state)
      S_READ: if (isKey1) nextState = S_UNL1;
      S_UNL1: if (busWrEn) nextState = isKey2 ? S_UNL2 : S_READ;
      S_UNL2: if (busWrEn) nextState = isProg ? S_PSET : (isESet ? S_ESET : S_READ);
      S_PSET: if (busWrEn) begin
        strb.latchPgm = 1'b1;
        nextState     = S_PGM;
        nextCnt       = LD_PGM;
      end
      S_ESET:  if (busWrEn) nextState = isKey1 ? S_EUNL1 : S_READ;
      S_EUNL1: if (busWrEn) nextState = isKey2 ? S_EUNL2 : S_READ;
      S_EUNL2: if (busWrEn) begin
        if (isChip) begin
          strb.allSectors = 1'b1;
          nextState       = S_PRE;
          nextCnt         = LD_PRE;
        end else if (isSect) begin
          strb.addSector = 1'b1;
          nextState      = S_WIN;
          nextCnt        = LD_WIN;
        end else begin
          nextState = S_READ;
        end
      end
      S_WIN: begin
        if (busWrEn) begin
          if (isSect) begin
            strb.addSector = 1'b1;
            nextCnt        = LD_WIN;
          end else begin
            strb.clearMask = 1'b1;
            nextState      = S_READ;
          end
        end else if (cnt == '0) begin
          nextState = S_ERASE;
          nextCnt   = LD_ERS;
        end else begin
          nextCnt = cnt - 1'b1;
        end
      end
      S_PGM: begin
        if (cnt == '0) begin
          strb.doProgram = 1'b1;
          nextState      = S_READ;
        end else nextCnt = cnt - 1'b1;
      end
      S_PRE: begin
        if (cnt == '0) begin
          strb.zeroAll = 1'b1;
          nextState    = S_ERASE;
          nextCnt      = LD_ERS;
        end else nextCnt = cnt - 1'b1;
      end
      S_ERASE: begin
        if (cnt == '0) begin
          strb.eraseMasked = 1'b1;
          nextState        = S_READ;
        end else nextCnt = cnt - 1'b1;
      end
      default: nextState = S_READ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_READ;
      cnt   <= '0;
    end else begin
      state <= nextState;
      cnt   <= nextCnt;
    end
  end

  always_comb begin
    case (state)
      S_PGM:                  rdMode = RD_PGM_STATUS;
      S_WIN, S_PRE, S_ERASE:  rdMode = RD_ERASE_STATUS;
      default:                rdMode = RD_ARRAY;
    endcase
  end

  // R1: only the first unlock cycle leaves read mode
  p_read_hold_r1: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_READ && !isKey1) |=> state == S_READ);

  // R5: an extra sector write restarts the window
  p_win_restart_r5: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_WIN && isSect) |=> (state == S_WIN && cnt == LD_WIN));

  // R6: a running program stays busy regardless of writes
  p_busy_ignore_r6: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_PGM && cnt != '0) |=> state == S_PGM);

  // R6: at most one datapath action per cycle
  p_strobe_onehot_r6: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strb));
endmodule

// File: rtl/flash_cmd_top.sv
module flash_cmd_top
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W       = 12,
  parameter int DEPTH        = 64,
  parameter int NSECT        = 4,
  parameter int PGM_CYCLES   = 8,
  parameter int WIN_CYCLES   = 16,
  parameter int PRE_CYCLES   = 12,
  parameter int ERASE_CYCLES = 20
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [7:0]        busWrData,
  input  logic              busWrEn,
  output logic [7:0]        busRdData
);
  localparam int IDX_W = $clog2(DEPTH);

  flStrobe_t strb;
  rdMode_t   rdMode;

  flash_cmd_ctrl #(
    .ADDR_W(ADDR_W), .PGM_CYCLES(PGM_CYCLES), .WIN_CYCLES(WIN_CYCLES),
    .PRE_CYCLES(PRE_CYCLES), .ERASE_CYCLES(ERASE_CYCLES)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrData(busWrData),
    .busWrEn(busWrEn), .strb(strb), .rdMode(rdMode)
  );

  flash_cmd_datapath #(.DEPTH(DEPTH), .NSECT(NSECT)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .rdMode(rdMode),
    .busIdx(busAddr[IDX_W-1:0]), .wrData(busWrData), .rdData(busRdData)
  );
endmodule

// File: tb/flash_cmd_top_bench.sv
module flash_cmd_top_bench;
  localparam int P   = 8;
  localparam int WIN = 16;
  localparam int PRE = 12;
  localparam int ERS = 20;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [11:0] busAddr = '0;
  logic [7:0]  busWrData = '0;
  logic        busWrEn = 1'b0;
  logic [7:0]  busRdData;

  int nChecks = 0;
  int nFail = 0;
  bit finished = 1'b0;

  typedef struct {
    logic [11:0] addr;
    logic [7:0]  exp;
    string       tag;
  } sbItem_t;
  sbItem_t sbq[$];

  always #10 clk = ~clk;

  flash_cmd_top #(.PGM_CYCLES(P), .WIN_CYCLES(WIN), .PRE_CYCLES(PRE),
                  .ERASE_CYCLES(ERS)) u_flash_cmd_top (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrData(busWrData),
    .busWrEn(busWrEn), .busRdData(busRdData)
  );

  // monitor: compares the queued expectation with the read data mid-cycle
  always @(negedge clk) begin
    if (sbq.size() != 0) begin
      sbItem_t it;
      it = sbq.pop_front();
      nChecks++;
      if (busRdData !== it.exp) begin
        nFail++;
        $display("FAIL %s addr=%h actual=%h expected=%h", it.tag, it.addr, busRdData, it.exp);
      end
    end
  end

  task automatic readNow(input logic [11:0] a, input logic [7:0] e, input string tag);
    sbItem_t it;
    busAddr = a;
    it.addr = a; it.exp = e; it.tag = tag;
    sbq.push_back(it);
    @(negedge clk);
    @(posedge clk);
    #1;
  endtask

  task automatic busWrite(input logic [11:0] a, input logic [7:0] d);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(posedge clk);
    #1 busWrEn = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic progSeq(input logic [11:0] a, input logic [7:0] d);
    busWrite(12'h555, 8'hAA);
    busWrite(12'h2AA, 8'h55);
    busWrite(12'h555, 8'hA0);
    busWrite(a, d);
  endtask

  task automatic eraseLead();
    busWrite(12'h555, 8'hAA);
    busWrite(12'h2AA, 8'h55);
    busWrite(12'h555, 8'h80);
    busWrite(12'h555, 8'hAA);
    busWrite(12'h2AA, 8'h55);
  endtask

  task automatic checkProg(input logic [11:0] a, input logic [7:0] d,
                           input logic [7:0] old, input string tag);
    for (int i = 0; i < P; i++) readNow(a, {~d[7], 7'b0}, {tag, " status R3"});
    readNow(a, old & d, {tag, " result"});
  endtask

  initial begin
    idle(3);
    rstN = 1'b1;
    // R8 reset state
    readNow(12'h003, 8'hFF, "R8 reset byte");
    readNow(12'h033, 8'hFF, "R8 reset byte");

    // R1 + R3 first program
    progSeq(12'h003, 8'h5A);
    checkProg(12'h003, 8'h5A, 8'hFF, "R1 program");
    // R2 AND behaviour
    progSeq(12'h003, 8'h0F);
    checkProg(12'h003, 8'h0F, 8'h5A, "R2 and");
    progSeq(12'h013, 8'h3C);
    checkProg(12'h013, 8'h3C, 8'hFF, "R3 pgm s1");
    progSeq(12'h023, 8'hC3);
    checkProg(12'h023, 8'hC3, 8'hFF, "R3 pgm s2 dq7=1");

    // R1 no unlock
    busWrite(12'h555, 8'hA0);
    busWrite(12'h004, 8'h00);
    idle(P + 2);
    readNow(12'h004, 8'hFF, "R1 program without unlock");
    // R7 F0 abort
    busWrite(12'h555, 8'hAA);
    busWrite(12'h2AA, 8'h55);
    busWrite(12'h555, 8'hF0);
    busWrite(12'h005, 8'h00);
    readNow(12'h005, 8'hFF, "R7 abort by F0");
    // R7 wrong address in second unlock
    busWrite(12'h555, 8'hAA);
    busWrite(12'h123, 8'h55);
    busWrite(12'h555, 8'hA0);
    busWrite(12'h006, 8'h00);
    readNow(12'h006, 8'hFF, "R7 wrong unlock address");

    // R6 writes ignored while programming
    progSeq(12'h033, 8'h11);
    busWrite(12'h555, 8'hAA);
    busWrite(12'h2AA, 8'h55);
    busWrite(12'h555, 8'hA0);
    busWrite(12'h034, 8'h00);
    for (int i = 0; i < P - 4; i++) readNow(12'h033, 8'h80, "R6 still busy");
    readNow(12'h033, 8'h11, "R6 program result");
    readNow(12'h034, 8'hFF, "R6 ignored program");
    readNow(12'h034, 8'hFF, "R6 no late start");

    // R5 sector erase, sectors 1 and 2, window restarted
    eraseLead();
    busWrite(12'h013, 8'h30);
    for (int i = 0; i < 5; i++) readNow(12'h013, 8'h00, "R5 window status");
    busWrite(12'h023, 8'h30);
    for (int i = 0; i < WIN + ERS; i++) readNow(12'h013, 8'h00, "R5 erase status");
    readNow(12'h013, 8'hFF, "R5 sector1 erased");
    readNow(12'h023, 8'hFF, "R5 sector2 erased");
    readNow(12'h003, 8'h0A, "R5 sector0 kept");
    readNow(12'h033, 8'h11, "R5 sector3 kept");

    // R9 window abandoned
    eraseLead();
    busWrite(12'h003, 8'h30);
    readNow(12'h003, 8'h00, "R9 window status");
    busWrite(12'h000, 8'h00);
    readNow(12'h003, 8'h0A, "R9 back to read");
    idle(WIN + ERS + 4);
    readNow(12'h003, 8'h0A, "R9 no erase later");

    // R4 chip erase
    eraseLead();
    busWrite(12'h555, 8'h10);
    for (int i = 0; i < PRE + ERS; i++) readNow(12'h003, 8'h00, "R4 chip status");
    readNow(12'h003, 8'hFF, "R4 chip erased");
    readNow(12'h033, 8'hFF, "R4 chip erased");
    readNow(12'h01F, 8'hFF, "R4 chip erased");

    // R2 programming after erase works again
    progSeq(12'h02E, 8'h81);
    checkProg(12'h02E, 8'h81, 8'hFF, "R2 after erase");

    idle(2);
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      nChecks++;
      nFail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end
endmodule